// File: doc/BRIEF.md
# Command-Pointer Register Access Unit

This block is the byte-level register front end of a serial-bus light-sensor slave. A bus engine in front of it has already found start and stop conditions and matched the slave address. That engine hands over four kinds of event: a transaction start, a written byte, a request for a read byte, and a stop. The unit keeps a 5-bit register pointer and a transfer mode between transactions. It steers written bytes into the configuration registers and returns one byte for each read request. It also emits a one-cycle pulse that clears the light interrupt.

The first byte written after a start is decoded as a command word only when its top bit is set. The command selects one of these behaviours:
- repeated access to one register;
- auto-increment, where the pointer moves on after every byte;
- a special function.

For each of the two 16-bit sample channels, reading the low byte freezes that channel's high byte in a shadow. A two-byte read therefore never mixes halves of two different conversions.

The bus-side interface has no back-pressure. The unit accepts one event per clock cycle, with priority start > write > read > stop if several are raised together. A read request is always answered on the cycle after it: `rd_valid` is high for exactly one cycle, and `rd_data` holds the byte during that cycle. The bus engine must hold off the next request itself if it cannot take the answer.

Top module: `cmdptr_regaccess`

## Requirements
- R1: After reset, the integration-time register (address 0x01) and the wait-time register (address 0x03) read as 0xFF. Every other writable register, `int_clear` and `rd_valid` are 0.
- R2: A first byte after start with bit 7 = 0 is not a command. It is written as data to the address held by the last command.
- R3: A command byte with bits 6:5 = 00 loads bits 4:0 into the pointer and selects repeat mode. In repeat mode every following read or write uses the same address.
- R4: Command type 01 loads the pointer and selects auto-increment mode. In that mode the pointer advances by one after each written or read byte and wraps from 0x1F to 0x00.
- R5: Command type 11 with bits 4:0 = 00110 (byte 0xE6) raises `int_clear` for exactly one cycle, starting the cycle after the byte. Other special codes and the reserved type 10 give no pulse and leave the pointer and the mode unchanged.
- R6: A read transaction without a command uses the pointer left by the previous transaction. A stop changes neither the pointer nor the mode.
- R7: Reading 0x14 returns ch0 bits 7:0 and stores ch0 bits 15:8 in a shadow. A later read of 0x15 returns the shadow even if `ch0_sample` has changed in between. Addresses 0x16/0x17 do the same for ch1.
- R8: 0x12 reads the `ID_VALUE` parameter. 0x13 reads the status byte, with bit 4 = `core_int_flag` and bit 0 = `core_data_valid`. Writes to 0x12, 0x13 or unmapped addresses change no register, and unmapped addresses read 0x00.
- R9: Each accepted read request gives `rd_valid` high for exactly the next cycle, with the byte on `rd_data`. `rd_valid` is low in all other cycles.
- R10: A data byte written to a writable register appears on the matching `cfg_*` output on the next cycle. The thresholds are assembled low byte first: 0x04/0x05 form the low threshold and 0x06/0x07 the high threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_start | input | 1 | Transaction start strobe |
| evt_stop | input | 1 | Transaction stop strobe |
| wr_valid | input | 1 | Written byte strobe |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read byte request |
| rd_valid | output | 1 | Read byte returned this cycle |
| rd_data | output | 8 | Returned byte |
| ch0_sample | input | 16 | Channel 0 conversion result |
| ch1_sample | input | 16 | Channel 1 conversion result |
| core_int_flag | input | 1 | Pending interrupt from the sensor core |
| core_data_valid | input | 1 | Conversion-complete flag from the core |
| int_clear | output | 1 | One-cycle interrupt clear pulse |
| cfg_enable | output | 8 | Register 0x00 |
| cfg_itime | output | 8 | Register 0x01 |
| cfg_wtime | output | 8 | Register 0x03 |
| cfg_lo_thr | output | 16 | Low threshold, 0x05:0x04 |
| cfg_hi_thr | output | 16 | High threshold, 0x07:0x06 |
| cfg_pers | output | 8 | Register 0x0C |
| cfg_config | output | 8 | Register 0x0D |
| cfg_control | output | 8 | Register 0x0F |

## Verification
The bench changes a channel sample between the low-byte and high-byte reads. A design without the shadow would return the new high byte. It reads across a stop and across a second start with no command; a design that reset the pointer on either event would return register 0x00 instead of the expected address. It writes from address 0x1F in auto-increment mode, where a missing wrap would lose the byte meant for 0x00. It sends the reserved command type and a non-clear special code; a decoder that did not fully qualify those codes would move the pointer or emit a stray clear pulse.

// File: rtl/cpra_pkg.sv
package cpra_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int NUM_CH = 2;
  localparam int NUM_RW = 10;

  typedef enum logic [1:0] {
    XFER_REPEAT  = 2'b00,
    XFER_AUTO    = 2'b01,
    XFER_RSVD    = 2'b10,
    XFER_SPECIAL = 2'b11
  } xfer_t;

  localparam logic [ADDR_W-1:0] SPF_INT_CLEAR = 5'b00110;
  localparam logic [ADDR_W-1:0] ID_ADDR       = 5'h12;
  localparam logic [ADDR_W-1:0] STATUS_ADDR   = 5'h13;
  localparam logic [ADDR_W-1:0] DATA_BASE     = 5'h14;
  localparam int STAT_INT_BIT   = 4;
  localparam int STAT_VALID_BIT = 0;

  // writable registers: 0 enable, 1 itime, 2 wtime, 3..6 thresholds, 7 pers, 8 config, 9 control
  localparam logic [ADDR_W-1:0] RW_ADDR [NUM_RW] =
    '{5'h00, 5'h01, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h0C, 5'h0D, 5'h0F};
  localparam logic [BYTE_W-1:0] RW_RESET [NUM_RW] =
    '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
endpackage

// File: rtl/cpra_cmd_ctrl.sv
module cpra_cmd_ctrl
  import cpra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_start,
  input  logic              evt_stop,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              int_clear
);
  logic  expect_cmd_q;
  logic  auto_q;
  logic  is_cmd;
  xfer_t cmd_type;
  logic [ADDR_W-1:0] cmd_addr;

  assign cmd_type = xfer_t'(wr_data[6:5]);
  assign cmd_addr = wr_data[ADDR_W-1:0];
  assign is_cmd   = expect_cmd_q && wr_data[7];
  assign wr_en    = wr_valid && !evt_start && !is_cmd;
  assign rd_en    = rd_req && !evt_start && !wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_cmd_q <= 1'b0;
      auto_q       <= 1'b0;
      ptr_q        <= '0;
      int_clear    <= 1'b0;
    end else begin
      int_clear <= 1'b0;
      if (evt_start) begin
        expect_cmd_q <= 1'b1;
      end else if (wr_valid) begin
        expect_cmd_q <= 1'b0;
        if (is_cmd) begin
          case (cmd_type)
            XFER_REPEAT: begin ptr_q <= cmd_addr; auto_q <= 1'b0; end
            XFER_AUTO:   begin ptr_q <= cmd_addr; auto_q <= 1'b1; end
            XFER_SPECIAL: if (cmd_addr == SPF_INT_CLEAR) int_clear <= 1'b1;
            default: ;
          endcase
        end else if (auto_q) begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else if (rd_req) begin
        expect_cmd_q <= 1'b0;
        if (auto_q) ptr_q <= ptr_q + 1'b1;
      end else if (evt_stop) begin
        expect_cmd_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpra_reg_bank.sv
module cpra_reg_bank
  import cpra_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [BYTE_W-1:0]              wdata,
  output logic [NUM_RW-1:0][BYTE_W-1:0]  regs
);
  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RW_RESET[i];
      else if (wr_en && addr == RW_ADDR[i])
        regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/cpra_read_port.sv
module cpra_read_port
  import cpra_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h5A
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_RW-1:0][BYTE_W-1:0]   regs,
  input  logic [NUM_CH-1:0][2*BYTE_W-1:0] samples,
  input  logic                            int_flag,
  input  logic                            data_valid,
  output logic                            rd_valid,
  output logic [BYTE_W-1:0]               rd_data
);
  logic [NUM_CH-1:0][BYTE_W-1:0] shadow_q;
  logic [BYTE_W-1:0] status_byte;
  logic [BYTE_W-1:0] mux_byte;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_shadow
    localparam logic [ADDR_W-1:0] LO_ADDR = DATA_BASE + ADDR_W'(2 * c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shadow_q[c] <= '0;
      else if (rd_en && addr == LO_ADDR)
        shadow_q[c] <= samples[c][2*BYTE_W-1:BYTE_W];
    end
  end

  always_comb begin
    status_byte = '0;
    status_byte[STAT_INT_BIT]   = int_flag;
    status_byte[STAT_VALID_BIT] = data_valid;
  end

  always_comb begin
    mux_byte = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (addr == RW_ADDR[i]) mux_byte = regs[i];
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == DATA_BASE + ADDR_W'(2 * c))     mux_byte = samples[c][BYTE_W-1:0];
      if (addr == DATA_BASE + ADDR_W'(2 * c + 1)) mux_byte = shadow_q[c];
    end
    if (addr == ID_ADDR)     mux_byte = ID_VALUE;
    if (addr == STATUS_ADDR) mux_byte = status_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux_byte;
    end
  end
endmodule

// File: rtl/cmdptr_regaccess.sv
module cmdptr_regaccess
  import cpra_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h5A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_start,
  input  logic                evt_stop,
  input  logic                wr_valid,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_req,
  output logic                rd_valid,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic [2*BYTE_W-1:0] ch0_sample,
  input  logic [2*BYTE_W-1:0] ch1_sample,
  input  logic                core_int_flag,
  input  logic                core_data_valid,
  output logic                int_clear,
  output logic [BYTE_W-1:0]   cfg_enable,
  output logic [BYTE_W-1:0]   cfg_itime,
  output logic [BYTE_W-1:0]   cfg_wtime,
  output logic [2*BYTE_W-1:0] cfg_lo_thr,
  output logic [2*BYTE_W-1:0] cfg_hi_thr,
  output logic [BYTE_W-1:0]   cfg_pers,
  output logic [BYTE_W-1:0]   cfg_config,
  output logic [BYTE_W-1:0]   cfg_control
);
  logic                            wr_en;
  logic                            rd_en;
  logic [ADDR_W-1:0]               ptr_q;
  logic [NUM_RW-1:0][BYTE_W-1:0]   regs;
  logic [NUM_CH-1:0][2*BYTE_W-1:0] samples;

  assign samples = {ch1_sample, ch0_sample};

  cpra_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .wr_en(wr_en), .rd_en(rd_en), .ptr_q(ptr_q), .int_clear(int_clear)
  );

  cpra_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr_q),
    .wdata(wr_data), .regs(regs)
  );

  cpra_read_port #(.ID_VALUE(ID_VALUE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(ptr_q), .regs(regs),
    .samples(samples), .int_flag(core_int_flag), .data_valid(core_data_valid),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign cfg_enable  = regs[0];
  assign cfg_itime   = regs[1];
  assign cfg_wtime   = regs[2];
  assign cfg_lo_thr  = {regs[4], regs[3]};
  assign cfg_hi_thr  = {regs[6], regs[5]};
  assign cfg_pers    = regs[7];
  assign cfg_config  = regs[8];
  assign cfg_control = regs[9];
endmodule

// File: rtl/cpra_checker.sv
module cpra_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       rd_req,
  input logic       rd_valid,
  input logic       int_clear,
  input logic [7:0] cfg_wtime,
  input logic [4:0] ptr
);
  p_rd_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !evt_start && !wr_valid) |=> rd_valid);

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_clear_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_clear |=> !int_clear);

  p_clear_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_clear |-> $past(wr_valid && wr_data == 8'hE6));

  p_stop_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stop && !evt_start && !wr_valid && !rd_req) |=> $stable(ptr));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(cfg_wtime));
endmodule

bind cmdptr_regaccess cpra_checker u_chk (
  .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
  .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
  .rd_valid(rd_valid), .int_clear(int_clear), .cfg_wtime(cfg_wtime),
  .ptr(ptr_q)
);

// File: tb/cmdptr_regaccess_bench.sv
module cmdptr_regaccess_bench;
  localparam int PERIOD = 20;
  localparam logic [1:0] OP_S = 2'd0, OP_W = 2'd1, OP_R = 2'd2, OP_P = 2'd3;
  localparam int NVEC = 49;
  // {req[3:0], op[1:0], data[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd3, OP_S, 8'h00, 8'h00}, {4'd3, OP_W, 8'h81, 8'h00}, // R3 cmd repeat @01
    {4'd3, OP_W, 8'h40, 8'h00}, {4'd3, OP_W, 8'h41, 8'h00},
    {4'd6, OP_S, 8'h00, 8'h00}, {4'd3, OP_R, 8'h00, 8'h41}, // R6 no cmd, R3 repeat
    {4'd3, OP_R, 8'h00, 8'h41},
    {4'd4, OP_S, 8'h00, 8'h00}, {4'd4, OP_W, 8'hA4, 8'h00}, // R4 auto @04
    {4'd4, OP_W, 8'h11, 8'h00}, {4'd4, OP_W, 8'h22, 8'h00},
    {4'd4, OP_W, 8'h33, 8'h00}, {4'd4, OP_W, 8'h44, 8'h00},
    {4'd4, OP_S, 8'h00, 8'h00}, {4'd4, OP_W, 8'hA4, 8'h00},
    {4'd4, OP_S, 8'h00, 8'h00}, {4'd4, OP_R, 8'h00, 8'h11},
    {4'd4, OP_R, 8'h00, 8'h22}, {4'd4, OP_R, 8'h00, 8'h33},
    {4'd4, OP_R, 8'h00, 8'h44},
    {4'd8, OP_S, 8'h00, 8'h00}, {4'd8, OP_W, 8'hB2, 8'h00}, // R8 ID/status
    {4'd8, OP_S, 8'h00, 8'h00}, {4'd8, OP_R, 8'h00, 8'h5A},
    {4'd8, OP_R, 8'h00, 8'h11}, {4'd7, OP_R, 8'h00, 8'h34}, // R7 channel bytes
    {4'd7, OP_R, 8'h00, 8'h12}, {4'd7, OP_R, 8'h00, 8'hCD},
    {4'd7, OP_R, 8'h00, 8'hAB},
    {4'd6, OP_P, 8'h00, 8'h00}, {4'd6, OP_S, 8'h00, 8'h00}, // R6 ptr kept over stop
    {4'd6, OP_R, 8'h00, 8'h00},
    {4'd8, OP_S, 8'h00, 8'h00}, {4'd8, OP_W, 8'h92, 8'h00}, // R8 write to ID ignored
    {4'd8, OP_W, 8'h77, 8'h00}, {4'd8, OP_S, 8'h00, 8'h00},
    {4'd8, OP_R, 8'h00, 8'h5A},
    {4'd8, OP_S, 8'h00, 8'h00}, {4'd8, OP_W, 8'h88, 8'h00}, // R8 unmapped
    {4'd8, OP_W, 8'h99, 8'h00}, {4'd8, OP_S, 8'h00, 8'h00},
    {4'd8, OP_R, 8'h00, 8'h00},
    {4'd2, OP_S, 8'h00, 8'h00}, {4'd2, OP_W, 8'h81, 8'h00}, // R2 data-first byte
    {4'd2, OP_P, 8'h00, 8'h00}, {4'd2, OP_S, 8'h00, 8'h00},
    {4'd2, OP_W, 8'h55, 8'h00}, {4'd2, OP_S, 8'h00, 8'h00},
    {4'd2, OP_R, 8'h00, 8'h55}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_start = 1'b0, evt_stop = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_valid, int_clear;
  logic [7:0] rd_data;
  logic [15:0] ch0_sample = 16'h1234, ch1_sample = 16'hABCD;
  logic core_int_flag = 1'b1, core_data_valid = 1'b1;
  logic [7:0] cfg_enable, cfg_itime, cfg_wtime, cfg_pers, cfg_config, cfg_control;
  logic [15:0] cfg_lo_thr, cfg_hi_thr;
  int checks = 0, failures = 0, clr_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  cmdptr_regaccess u_cmdptr_regaccess (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .ch0_sample(ch0_sample),
    .ch1_sample(ch1_sample), .core_int_flag(core_int_flag),
    .core_data_valid(core_data_valid), .int_clear(int_clear),
    .cfg_enable(cfg_enable), .cfg_itime(cfg_itime), .cfg_wtime(cfg_wtime),
    .cfg_lo_thr(cfg_lo_thr), .cfg_hi_thr(cfg_hi_thr), .cfg_pers(cfg_pers),
    .cfg_config(cfg_config), .cfg_control(cfg_control)
  );

  always @(negedge clk) if (rst_n && int_clear) clr_cnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [1:0] op, input logic [7:0] d);
    evt_start = (op == OP_S);
    wr_valid  = (op == OP_W);
    rd_req    = (op == OP_R);
    evt_stop  = (op == OP_P);
    wr_data   = d;
    @(negedge clk);
    evt_start = 1'b0; wr_valid = 1'b0; rd_req = 1'b0; evt_stop = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    step(OP_R, 8'h00);
    chk(req, {7'd0, rd_valid, rd_data}, {8'h01, exp});
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 itime", {8'd0, cfg_itime}, 16'h00FF);
    chk("R1 wtime", {8'd0, cfg_wtime}, 16'h00FF);
    chk("R1 others", {cfg_enable, cfg_pers, cfg_config, cfg_control} == 32'd0 &&
        cfg_lo_thr == 16'd0 && cfg_hi_thr == 16'd0, 16'd1);
    chk("R1 outputs", {14'd0, rd_valid, int_clear}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step(OP_S, 8'h00); step(OP_W, 8'h83); step(OP_S, 8'h00);
    rd_chk("R1 wtime read", 8'hFF);
    // R9 single-cycle valid
    @(negedge clk);
    chk("R9 valid drops", {15'd0, rd_valid}, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] rq;
      logic [1:0] op;
      logic [7:0] d, e;
      {rq, op, d, e} = VEC[i];
      step(op, d);
      if (op == OP_R)
        chk($sformatf("R%0d vec%0d", rq, i), {7'd0, rd_valid, rd_data}, {8'h01, e});
    end

    // R10 config outputs
    chk("R10 itime", {8'd0, cfg_itime}, 16'h0055);
    chk("R10 lo thr", cfg_lo_thr, 16'h2211);
    chk("R10 hi thr", cfg_hi_thr, 16'h4433);

    // R5 reserved type and non-clear special: no pulse, pointer/mode kept
    step(OP_S, 8'h00); step(OP_W, 8'hC6); step(OP_S, 8'h00); step(OP_W, 8'hE5);
    step(OP_S, 8'h00);
    rd_chk("R5 ptr kept", 8'h55);
    rd_chk("R5 repeat kept", 8'h55);
    chk("R5 no pulse", clr_cnt[15:0], 16'd0);
    step(OP_S, 8'h00); step(OP_W, 8'hE6);
    @(negedge clk); @(negedge clk);
    chk("R5 one pulse", clr_cnt[15:0], 16'd1);
    step(OP_S, 8'h00);
    rd_chk("R5 ptr after clear", 8'h55);

    // R4 wrap 0x1F -> 0x00
    step(OP_S, 8'h00); step(OP_W, 8'hBF); step(OP_W, 8'h12); step(OP_W, 8'h13);
    chk("R4 wrap write", {8'd0, cfg_enable}, 16'h0013);
    step(OP_S, 8'h00); step(OP_W, 8'hBF); step(OP_S, 8'h00);
    rd_chk("R4 unmapped 1F", 8'h00);
    rd_chk("R4 wrapped read", 8'h13);

    // R7 shadow holds across sample change
    step(OP_S, 8'h00); step(OP_W, 8'hB4); step(OP_S, 8'h00);
    rd_chk("R7 ch0 low", 8'h34);
    ch0_sample = 16'h9876;
    rd_chk("R7 ch0 shadow", 8'h12);
    rd_chk("R7 ch1 low", 8'hCD);
    ch1_sample = 16'h4321;
    rd_chk("R7 ch1 shadow", 8'hAB);

    // R8 status bits follow the core flags
    core_int_flag = 1'b0;
    step(OP_S, 8'h00); step(OP_W, 8'h93); step(OP_S, 8'h00);
    rd_chk("R8 status", 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule